// File: doc/BRIEF.md
# Cascaded Programmable Clock Divider

This block divides a fast input clock down to a slow output clock with equal high and low times. Division happens in a fixed chain of counters that all run on the input clock. An odd-ratio stage comes first, then two general integer stages, and a final toggle flop halves the rate. Each stage emits a one-cycle enable when it wraps, and that enable steps the next stage. Symmetry comes only from the final toggle, so the upstream ratios may be odd or uneven without any per-stage duty correction.

A configuration interface drives three ratio fields. The block copies them into internal shadow copies at reset and at every wrap of the last counter stage. A ratio change therefore never shortens or stretches the half period that is in progress. Besides the divided clock, the block gives a one-cycle pulse each time the output changes level. Logic that runs on the fast clock can use this pulse as an edge strobe.

Top module: `clk_cascade_div`

## Requirements
- R1: While `rst` is high at a rising input edge, `clk_out` and `edge_pulse` are both 0 after that edge.
- R2: `h_sel` selects the odd ratio H: 2'b00 gives 1, 2'b01 gives 3, 2'b10 gives 5 and 2'b11 gives 7.
- R3: `l_m1` holds L−1 in 6 bits, so L runs from 1 (6'd0) to 64 (6'd63).
- R4: `x_m1` holds X−1 in 8 bits, so X runs from 1 (8'd0) to 256 (8'd255).
- R5: `clk_out` stays high for exactly H·L·X input cycles and stays low for exactly H·L·X input cycles, so one output period is 2·H·L·X input cycles.
- R6: After `rst` is released, the first rising edge of `clk_out` appears after exactly H·L·X rising input edges.
- R7: `edge_pulse` is high for exactly the input cycles in which `clk_out` has just changed level, and is low in every other cycle.
- R8: A change to the ratio fields during a half period has no effect on that half period. The new ratios govern the half periods that start after the next wrap of the last counter stage.
- R9: With H=1, L=1 and X=1, `clk_out` toggles on every rising input edge.
- R10: With H=5, L=50 and X=100, one output period is 50000 input cycles. A 6.25 MHz input therefore gives a 125 Hz output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| h_sel | input | 2 | Odd first-stage ratio code |
| l_m1 | input | 6 | Second-stage ratio minus one |
| x_m1 | input | 8 | Third-stage ratio minus one |
| clk_out | output | 1 | Divided clock with 50% duty cycle |
| edge_pulse | output | 1 | One-cycle strobe on each clk_out transition |

## Verification
The bench builds the block with its default field widths: 6 bits for the second stage and 8 bits for the third. With these widths it can reach the end values of each field: L of 64 and X of 256. The first-stage codes are swept one by one with the other stages at 1. Separate runs cover the all-ones pass-through case, a mixed ratio and the 50000-cycle worked example. A ratio change issued mid-period shows that the half period in progress keeps its old length.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int HSEL_W = 2;
  localparam int HCNT_W = 3;

  // Reload value of the odd stage: ratio 2*sel+1 minus one.
  function automatic logic [HCNT_W-1:0] odd_reload(input logic [HSEL_W-1:0] sel);
    return {sel, 1'b0};
  endfunction

  function automatic int unsigned odd_ratio(input logic [HSEL_W-1:0] sel);
    return 32'(sel) * 2 + 1;
  endfunction

  // Input cycles per output half period.
  function automatic int unsigned half_cycles(input logic [HSEL_W-1:0] sel,
                                              input int unsigned l_m1,
                                              input int unsigned x_m1);
    return odd_ratio(sel) * (l_m1 + 1) * (x_m1 + 1);
  endfunction
endpackage

// File: rtl/clkdiv_stage.sv
`timescale 1ns/1ps
module clkdiv_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_in,
  input  logic [W-1:0] reload_m1,
  output logic         en_out
);
  logic [W-1:0] cnt;
  logic         at_zero;

  assign at_zero = (cnt == '0);
  assign en_out  = en_in & at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= reload_m1;
    end else if (en_in) begin
      if (at_zero) cnt <= reload_m1;
      else         cnt <= cnt - 1'b1;
    end
  end

  // The count never exceeds the ratio in force.
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= reload_m1);

  // Without an incoming enable the stage holds its count.
  assert_count_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en_in |=> $stable(cnt));
endmodule

// File: rtl/clkdiv_shadow.sv
`timescale 1ns/1ps
module clkdiv_shadow
  import clkdiv_pkg::*;
#(
  parameter int L_W = 6,
  parameter int X_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              apply,
  input  logic [HSEL_W-1:0] h_sel,
  input  logic [L_W-1:0]    l_m1,
  input  logic [X_W-1:0]    x_m1,
  output logic [HCNT_W-1:0] h_rl,
  output logic [L_W-1:0]    l_rl,
  output logic [X_W-1:0]    x_rl,
  output logic [HSEL_W-1:0] h_act,
  output logic [L_W-1:0]    l_act,
  output logic [X_W-1:0]    x_act
);
  logic              take;
  logic [HSEL_W-1:0] h_eff;

  assign take  = rst | apply;
  assign h_eff = take ? h_sel : h_act;
  assign h_rl  = odd_reload(h_eff);
  assign l_rl  = take ? l_m1 : l_act;
  assign x_rl  = take ? x_m1 : x_act;

  always_ff @(posedge clk) begin
    if (take) begin
      h_act <= h_sel;
      l_act <= l_m1;
      x_act <= x_m1;
    end
  end

  // Ratios stay frozen between wraps of the last stage.
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !apply |=> ($stable(h_act) && $stable(l_act) && $stable(x_act)));

  // At a wrap the requested ratios are captured.
  assert_shadow_take_R8: assert property (@(posedge clk) disable iff (rst)
    apply |=> (h_act == $past(h_sel) && l_act == $past(l_m1) && x_act == $past(x_m1)));
endmodule

// File: rtl/clkdiv_out.sv
`timescale 1ns/1ps
module clkdiv_out (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic clk_out,
  output logic edge_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_out    <= 1'b0;
      edge_pulse <= 1'b0;
    end else begin
      clk_out    <= clk_out ^ tick;
      edge_pulse <= tick;
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (!clk_out && !edge_pulse));

  assert_pulse_marks_edge_R7: assert property (@(posedge clk) disable iff (rst)
    edge_pulse |-> (clk_out != $past(clk_out)));

  assert_no_pulse_no_edge_R7: assert property (@(posedge clk) disable iff (rst)
    !edge_pulse |-> $stable(clk_out));
endmodule

// File: rtl/clk_cascade_div.sv
`timescale 1ns/1ps
module clk_cascade_div
  import clkdiv_pkg::*;
#(
  parameter int L_W = 6,
  parameter int X_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HSEL_W-1:0] h_sel,
  input  logic [L_W-1:0]    l_m1,
  input  logic [X_W-1:0]    x_m1,
  output logic              clk_out,
  output logic              edge_pulse
);
  localparam int GAP_W = HCNT_W + L_W + X_W + 1;

  logic              h_tick, l_tick, x_tick;
  logic [HCNT_W-1:0] h_rl;
  logic [L_W-1:0]    l_rl;
  logic [X_W-1:0]    x_rl;
  logic [HSEL_W-1:0] h_act;
  logic [L_W-1:0]    l_act;
  logic [X_W-1:0]    x_act;

  clkdiv_shadow #(.L_W(L_W), .X_W(X_W)) u_shadow (
    .clk(clk), .rst(rst), .apply(x_tick),
    .h_sel(h_sel), .l_m1(l_m1), .x_m1(x_m1),
    .h_rl(h_rl), .l_rl(l_rl), .x_rl(x_rl),
    .h_act(h_act), .l_act(l_act), .x_act(x_act)
  );

  clkdiv_stage #(.W(HCNT_W)) u_odd (
    .clk(clk), .rst(rst), .en_in(1'b1), .reload_m1(h_rl), .en_out(h_tick)
  );

  clkdiv_stage #(.W(L_W)) u_mid (
    .clk(clk), .rst(rst), .en_in(h_tick), .reload_m1(l_rl), .en_out(l_tick)
  );

  clkdiv_stage #(.W(X_W)) u_last (
    .clk(clk), .rst(rst), .en_in(l_tick), .reload_m1(x_rl), .en_out(x_tick)
  );

  clkdiv_out u_out (
    .clk(clk), .rst(rst), .tick(x_tick), .clk_out(clk_out), .edge_pulse(edge_pulse)
  );

  // Checker: cycles between wraps of the last stage.
  logic [GAP_W-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst || x_tick) gap <= GAP_W'(1);
    else               gap <= gap + 1'b1;
  end

  assert_half_len_R5: assert property (@(posedge clk) disable iff (rst)
    x_tick |-> (32'(gap) == half_cycles(h_act, 32'(l_act), 32'(x_act))));
endmodule

// File: tb/tb_clk_cascade_div.sv
`timescale 1ns/1ps
module tb_clk_cascade_div;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] h_sel = 2'd0;
  logic [5:0] l_m1 = 6'd0;
  logic [7:0] x_m1 = 8'd0;
  logic       clk_out, edge_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  clk_cascade_div dut (
    .clk(clk), .rst(rst), .h_sel(h_sel), .l_m1(l_m1), .x_m1(x_m1),
    .clk_out(clk_out), .edge_pulse(edge_pulse)
  );

  always #10 clk = ~clk;

  function automatic int exp_half(input int h, input int l, input int x);
    int hr;
    case (h)
      0: hr = 1;
      1: hr = 3;
      2: hr = 5;
      default: hr = 7;
    endcase
    return hr * (l + 1) * (x + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input int h, input int l, input int x);
    @(negedge clk);
    h_sel = 2'(h); l_m1 = 6'(l); x_m1 = 8'(x);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Count rising input edges until edge_pulse is seen (sampled at negedge).
  task automatic to_pulse(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!edge_pulse && n < 300000);
  endtask

  task automatic t_reset;
    start(3, 5, 5);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(clk_out == 0, "R1 clk_out in reset", int'(clk_out), 0);
    check(edge_pulse == 0, "R1 edge_pulse in reset", int'(edge_pulse), 0);
    rst = 1'b0;
  endtask

  task automatic t_ratio(input int h, input int l, input int x, input string req);
    int n, e;
    e = exp_half(h, l, x);
    start(h, l, x);
    to_pulse(n);
    check(n == e && clk_out == 1, {req, " R6 first rise"}, n, e);
    to_pulse(n);
    check(n == e && clk_out == 0, {req, " R5 high time"}, n, e);
    to_pulse(n);
    check(n == e && clk_out == 1, {req, " R5 low time"}, n, e);
  endtask

  task automatic t_all_one;
    start(0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(clk_out == ((i % 2) == 0) && edge_pulse == 1, "R9 toggle each cycle",
            int'(clk_out), (i % 2) == 0 ? 1 : 0);
    end
  endtask

  task automatic t_pulse;
    int n, cnt, lvl;
    start(1, 1, 0);
    to_pulse(n);
    lvl = int'(clk_out);
    @(posedge clk);
    @(negedge clk);
    check(edge_pulse == 0, "R7 pulse one cycle wide", int'(edge_pulse), 0);
    check(int'(clk_out) == lvl, "R7 no change without pulse", int'(clk_out), lvl);
    cnt = 0;
    for (int i = 0; i < 59; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (edge_pulse) cnt++;
    end
    check(cnt == 10, "R7 pulse count in 60 cycles", cnt, 10);
  endtask

  task automatic t_reconfig;
    int n;
    start(0, 3, 1);
    to_pulse(n);
    check(n == 8, "R8 initial half", n, 8);
    repeat (3) @(posedge clk);
    @(negedge clk);
    h_sel = 2'd1; l_m1 = 6'd0; x_m1 = 8'd0;
    check(edge_pulse == 0, "R8 no early edge", int'(edge_pulse), 0);
    to_pulse(n);
    check(n + 3 == 8, "R8 current half keeps old length", n + 3, 8);
    to_pulse(n);
    check(n == 3, "R8 new ratio after wrap", n, 3);
  endtask

  task automatic t_example;
    int n, hi, lo;
    start(2, 49, 99);
    to_pulse(n);
    check(n == 25000, "R10 first rise", n, 25000);
    to_pulse(hi);
    to_pulse(lo);
    check(hi + lo == 50000, "R10 period 50000", hi + lo, 50000);
    check(hi == lo, "R10 symmetric", hi, lo);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_all_one();
    t_ratio(1, 0, 0, "R2 code 01");
    t_ratio(2, 0, 0, "R2 code 10");
    t_ratio(3, 0, 0, "R2 code 11");
    t_ratio(0, 63, 1, "R3 L=64");
    t_ratio(0, 0, 255, "R4 X=256");
    t_ratio(3, 3, 4, "R5 mixed");
    t_pulse();
    t_reconfig();
    t_example();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule